// File: doc/BRIEF.md
# Floating-Point Instruction Decoder

This block takes one 32-bit floating-point instruction word per cycle and turns it into a decoded record that an issue stage can use directly. The record names the operation and the operand layout class. It carries the five-bit register indices and the small immediates that the class uses. It also gives the address-generation style for memory forms, whether the base register is written back, the record bit, and a flag for words that must not execute. Address arithmetic, the register files and the arithmetic units sit outside the block.

The decode itself is combinational. A control half classifies the word from its primary and extended opcode fields and hands a small set of field-enable strobes to a datapath half. The datapath extracts and gates the fields and registers the whole record. `outValid` follows `inValid` one cycle later. While `inValid` is low, the registered record holds its last value.

Top module: `fp_insn_decode`

## Requirements
- R1: Reset clears every output to zero. A word presented with `inValid` high appears on the outputs at the next clock edge with `outValid` high. A clock edge with `inValid` low drops `outValid` and leaves every other output unchanged.
- R2: Primary opcode (bits 31:26) 48 to 55 is a displacement memory form with `opCode` = primary − 48. Odd primaries are update forms: `isUpdate` = 1 and `fmtClass` = 1. Even primaries give `fmtClass` = 0. `regT` = bits 25:21, `regA` = bits 20:16, and `dispExt` = bits 15:0 sign-extended to 32 bits.
- R3: In a displacement form, a base index of zero gives `addrMode` = 2 (zero base); a non-zero base index gives `addrMode` = 1. An update displacement form with base index zero is illegal.
- R4: Primary 31 decodes the extended field at bits 10:1. Values 535 + 32·k for k = 0..7 give `opCode` = 8 + k, with `isUpdate` = 1 for odd k. Odd k gives `fmtClass` = 3 and even k gives `fmtClass` = 2. Value 983 gives `opCode` = 16 and `fmtClass` = 2. These forms output `regT`, `regA` and `regB` (bits 15:11), and a non-zero base index gives `addrMode` = 3.
- R5: A non-update indexed form with base index zero is illegal, except extended value 983, which gives `addrMode` = 4 (index register only).
- R6: An indexed update form with base index zero is legal and gives `addrMode` = 4 with `isUpdate` = 1.
- R7: Primary 59 decodes bits 5:1 as a sub-opcode s with `opCode` = 32 + s. Values 18, 20, 21, 22 and 24 give `fmtClass` = 4 (T, A, B). Value 25 gives `fmtClass` = 5 (T, A, C). Values 28 to 31 give `fmtClass` = 6 (T, A, B, C). Any other s is illegal.
- R8: Primary 63 with bit 5 set uses the same sub-opcode field with `opCode` = 64 + s. It accepts 18, 20, 21, 22 and 26 as class 4, 25 as class 5, and 23 and 28 to 31 as class 6. Value 24 is illegal there, as are all other values.
- R9: Primary 63 with bit 5 clear decodes bits 10:1 against the ascending list 0, 12, 14, 15, 32, 38, 40, 64, 70, 72, 134, 136, 264, 583, 711, giving `opCode` = 96 + position in the list. The classes are: 0 and 32 compare (8); 64 field-to-condition (9); 38 and 70 bit set/clear (10); 134 immediate field (11); 711 masked move (12); 583 target only (13); all others target and B (7).
- R10: Fields not used by the class read zero. Class 8 gives `crField` = bits 25:23, `regA` and `regB`. Class 9 gives `crField` = bits 25:23 and `srcField` = bits 20:18. Class 10 gives the bit number (bits 25:21) on `regT`. Class 11 gives `crField` = bits 25:23 and `immNib` = bits 15:12. Class 12 gives `fieldMask` = bits 24:17 and `regB`. Class 13 gives only `regT`. `regC` = bits 10:6 only in classes 5 and 6. `dispExt` is non-zero only in classes 0 and 1.
- R11: `recordBit` equals bit 0 for legal words with primary 59 or 63, and is zero otherwise.
- R12: Any primary opcode or extended value not listed is illegal. An illegal word outputs `isIllegal` = 1, `opCode` = 127 and `fmtClass` = 15, with every other field and flag zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction word is present this cycle |
| insn | input | 32 | Instruction word |
| outValid | output | 1 | Registered record is new this cycle |
| opCode | output | 7 | Operation code |
| fmtClass | output | 4 | Operand layout class |
| addrMode | output | 3 | 0 none, 1 base+disp, 2 zero+disp, 3 base+index, 4 index only |
| isUpdate | output | 1 | Base register is written back |
| recordBit | output | 1 | Condition record requested |
| isIllegal | output | 1 | Word must trap |
| regT | output | 5 | Target index or bit number |
| regA | output | 5 | A / base index |
| regB | output | 5 | B / index register |
| regC | output | 5 | C index |
| crField | output | 3 | Condition or status field number |
| srcField | output | 3 | Source status field |
| immNib | output | 4 | 4-bit immediate |
| fieldMask | output | 8 | Status field mask |
| dispExt | output | 32 | Sign-extended displacement |

## Verification
The hardest cases to reach are the base-index-zero cases. Whether such a word is legal depends jointly on the primary opcode, the update parity and one specific extended value, and uniform random words almost never land on a listed extended value with bits 20:16 all zero. The stimulus therefore first chooses a legal opcode family and a listed extended value or sub-opcode, then forces the base field to zero about a quarter of the time. Directed words also cover the lone 983 exception, an indexed update with a zero base, a zero-base displacement update, and the sub-opcodes 23, 24 and 26 that differ between the two arithmetic groups.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;
  parameter int INSN_W   = 32;
  parameter int REG_W    = 5;
  parameter int OP_W     = 7;
  parameter int DISP_W   = 32;
  parameter int CRF_W    = 3;
  parameter int IMM_W    = 4;
  parameter int MASK_W   = 8;
  parameter int PRI_W    = 6;
  parameter int EXT_W    = 10;
  localparam int DISP_SRC_W = 16;
  localparam int FIELD_W    = INSN_W - PRI_W;
  localparam logic [OP_W-1:0] OP_BAD = '1;

  typedef enum logic [3:0] {
    FMT_DISP  = 4'd0,
    FMT_DISPU = 4'd1,
    FMT_IDX   = 4'd2,
    FMT_IDXU  = 4'd3,
    FMT_TAB   = 4'd4,
    FMT_TAC   = 4'd5,
    FMT_TABC  = 4'd6,
    FMT_TB    = 4'd7,
    FMT_CMP   = 4'd8,
    FMT_TOCR  = 4'd9,
    FMT_BIT   = 4'd10,
    FMT_IMM   = 4'd11,
    FMT_MASK  = 4'd12,
    FMT_T     = 4'd13,
    FMT_NONE  = 4'd15
  } fmt_e;

  typedef enum logic [2:0] {
    AM_NONE      = 3'd0,
    AM_BASE_DISP = 3'd1,
    AM_ZERO_DISP = 3'd2,
    AM_BASE_IDX  = 3'd3,
    AM_IDX_ONLY  = 3'd4
  } amode_e;

  typedef struct packed {
    logic useT;
    logic useA;
    logic useB;
    logic useC;
    logic useCr;
    logic useSrc;
    logic useImm;
    logic useMask;
    logic useDisp;
  } fieldStrobe_t;

  typedef struct packed {
    logic [OP_W-1:0] opCode;
    fmt_e            fmt;
    amode_e          amode;
    logic            update;
    logic            record;
    logic            illegal;
  } decodeInfo_t;
endpackage

// File: rtl/fpdec_ctrl.sv
module fpdec_ctrl
  import fpdec_pkg::*;
(
  input  logic [PRI_W-1:0] primary,
  input  logic [REG_W-1:0] baseIdx,
  input  logic [EXT_W-1:0] extOp,
  input  logic             recIn,
  output decodeInfo_t      info,
  output fieldStrobe_t     strobe
);
  localparam logic [PRI_W-1:0] PRI_IDX    = PRI_W'(31);
  localparam logic [PRI_W-1:0] PRI_SGL    = PRI_W'(59);
  localparam logic [PRI_W-1:0] PRI_DBL    = PRI_W'(63);
  localparam logic [PRI_W-1:0] PRI_MEM_LO = PRI_W'(48);
  localparam logic [PRI_W-1:0] PRI_MEM_HI = PRI_W'(55);
  localparam logic [EXT_W-1:0] EXT_IDX_BASE = EXT_W'(535);
  localparam logic [EXT_W-1:0] EXT_IDX_SPAN = EXT_W'(256);
  localparam logic [EXT_W-1:0] EXT_INT_STORE = EXT_W'(983);

  logic [4:0]       subOp;
  logic             baseZero;
  logic [EXT_W-1:0] idxOff;
  logic [4:0]       xRank;
  fmt_e             xFmt;
  logic             legal;
  logic             upd;
  fmt_e             fmt;
  amode_e           am;
  logic [OP_W-1:0]  op;
  logic             isArith;

  assign subOp    = extOp[4:0];
  assign baseZero = (baseIdx == '0);
  assign idxOff   = extOp - EXT_IDX_BASE;
  assign isArith  = (primary == PRI_SGL) || (primary == PRI_DBL);

  function automatic fmt_e arithClass(input logic [4:0] s, input logic dbl);
    case (s)
      5'd18, 5'd20, 5'd21, 5'd22: return FMT_TAB;
      5'd24:                      return dbl ? FMT_NONE : FMT_TAB;
      5'd26:                      return dbl ? FMT_TAB : FMT_NONE;
      5'd23:                      return dbl ? FMT_TABC : FMT_NONE;
      5'd25:                      return FMT_TAC;
      5'd28, 5'd29, 5'd30, 5'd31: return FMT_TABC;
      default:                    return FMT_NONE;
    endcase
  endfunction

  // X-form table of the double group, ranked by ascending extended value
  always_comb begin
    xRank = 5'd0;
    xFmt  = FMT_NONE;
    case (extOp)
      10'd0:   begin xRank = 5'd0;  xFmt = FMT_CMP;  end
      10'd12:  begin xRank = 5'd1;  xFmt = FMT_TB;   end
      10'd14:  begin xRank = 5'd2;  xFmt = FMT_TB;   end
      10'd15:  begin xRank = 5'd3;  xFmt = FMT_TB;   end
      10'd32:  begin xRank = 5'd4;  xFmt = FMT_CMP;  end
      10'd38:  begin xRank = 5'd5;  xFmt = FMT_BIT;  end
      10'd40:  begin xRank = 5'd6;  xFmt = FMT_TB;   end
      10'd64:  begin xRank = 5'd7;  xFmt = FMT_TOCR; end
      10'd70:  begin xRank = 5'd8;  xFmt = FMT_BIT;  end
      10'd72:  begin xRank = 5'd9;  xFmt = FMT_TB;   end
      10'd134: begin xRank = 5'd10; xFmt = FMT_IMM;  end
      10'd136: begin xRank = 5'd11; xFmt = FMT_TB;   end
      10'd264: begin xRank = 5'd12; xFmt = FMT_TB;   end
      10'd583: begin xRank = 5'd13; xFmt = FMT_T;    end
      10'd711: begin xRank = 5'd14; xFmt = FMT_MASK; end
      default: begin xRank = 5'd0;  xFmt = FMT_NONE; end
    endcase
  end

  always_comb begin
    legal = 1'b1;
    upd   = 1'b0;
    am    = AM_NONE;
    op    = '0;
    fmt   = FMT_NONE;
    if (primary >= PRI_MEM_LO && primary <= PRI_MEM_HI) begin
      op  = OP_W'(primary - PRI_MEM_LO);
      upd = primary[0];
      fmt = upd ? FMT_DISPU : FMT_DISP;
      am  = baseZero ? AM_ZERO_DISP : AM_BASE_DISP;
      if (upd && baseZero) legal = 1'b0;
    end else if (primary == PRI_IDX) begin
      if (extOp == EXT_INT_STORE) begin
        op  = OP_W'(16);
        fmt = FMT_IDX;
      end else if (idxOff[4:0] == 5'd0 && idxOff < EXT_IDX_SPAN) begin
        op  = OP_W'({2'b01, idxOff[7:5]});
        upd = idxOff[5];
        fmt = upd ? FMT_IDXU : FMT_IDX;
      end
      if (fmt == FMT_NONE)                    legal = 1'b0;
      else if (!baseZero)                     am = AM_BASE_IDX;
      else if (upd || extOp == EXT_INT_STORE) am = AM_IDX_ONLY;
      else                                    legal = 1'b0;
    end else if (primary == PRI_SGL) begin
      fmt   = arithClass(subOp, 1'b0);
      op    = OP_W'({2'b01, subOp});
      legal = (fmt != FMT_NONE);
    end else if (primary == PRI_DBL && extOp[4]) begin
      fmt   = arithClass(subOp, 1'b1);
      op    = OP_W'({2'b10, subOp});
      legal = (fmt != FMT_NONE);
    end else if (primary == PRI_DBL) begin
      fmt   = xFmt;
      op    = OP_W'({2'b11, xRank});
      legal = (fmt != FMT_NONE);
    end else begin
      legal = 1'b0;
    end

    if (legal) begin
      info.opCode  = op;
      info.fmt     = fmt;
      info.amode   = am;
      info.update  = upd;
      info.record  = recIn && isArith;
      info.illegal = 1'b0;
    end else begin
      info.opCode  = OP_BAD;
      info.fmt     = FMT_NONE;
      info.amode   = AM_NONE;
      info.update  = 1'b0;
      info.record  = 1'b0;
      info.illegal = 1'b1;
    end
  end

  // Field-enable strobes handed to the datapath
  always_comb begin
    strobe = '0;
    case (info.fmt)
      FMT_DISP, FMT_DISPU: begin strobe.useT = 1'b1; strobe.useA = 1'b1; strobe.useDisp = 1'b1; end
      FMT_IDX, FMT_IDXU, FMT_TAB: begin strobe.useT = 1'b1; strobe.useA = 1'b1; strobe.useB = 1'b1; end
      FMT_TAC:  begin strobe.useT = 1'b1; strobe.useA = 1'b1; strobe.useC = 1'b1; end
      FMT_TABC: begin strobe.useT = 1'b1; strobe.useA = 1'b1; strobe.useB = 1'b1; strobe.useC = 1'b1; end
      FMT_TB:   begin strobe.useT = 1'b1; strobe.useB = 1'b1; end
      FMT_CMP:  begin strobe.useCr = 1'b1; strobe.useA = 1'b1; strobe.useB = 1'b1; end
      FMT_TOCR: begin strobe.useCr = 1'b1; strobe.useSrc = 1'b1; end
      FMT_BIT, FMT_T: strobe.useT = 1'b1;
      FMT_IMM:  begin strobe.useCr = 1'b1; strobe.useImm = 1'b1; end
      FMT_MASK: begin strobe.useMask = 1'b1; strobe.useB = 1'b1; end
      default:  strobe = '0;
    endcase
  end
endmodule

// File: rtl/fpdec_datapath.sv
module fpdec_datapath
  import fpdec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [FIELD_W-1:0] fieldBits,
  input  decodeInfo_t        info,
  input  fieldStrobe_t       strobe,
  output logic               outValid,
  output logic [OP_W-1:0]    opCode,
  output logic [3:0]         fmtClass,
  output logic [2:0]         addrMode,
  output logic               isUpdate,
  output logic               recordBit,
  output logic               isIllegal,
  output logic [REG_W-1:0]   regT,
  output logic [REG_W-1:0]   regA,
  output logic [REG_W-1:0]   regB,
  output logic [REG_W-1:0]   regC,
  output logic [CRF_W-1:0]   crField,
  output logic [CRF_W-1:0]   srcField,
  output logic [IMM_W-1:0]   immNib,
  output logic [MASK_W-1:0]  fieldMask,
  output logic [DISP_W-1:0]  dispExt
);
  localparam int T_LSB    = 21;
  localparam int A_LSB    = 16;
  localparam int B_LSB    = 11;
  localparam int C_LSB    = 6;
  localparam int CR_LSB   = 23;
  localparam int SRC_LSB  = 18;
  localparam int IMM_LSB  = 12;
  localparam int MASK_LSB = 17;

  logic [REG_W-1:0]  nextT, nextA, nextB, nextC;
  logic [CRF_W-1:0]  nextCr, nextSrc;
  logic [IMM_W-1:0]  nextImm;
  logic [MASK_W-1:0] nextMask;
  logic [DISP_W-1:0] rawDisp, nextDisp;

  generate
    if (DISP_W > DISP_SRC_W) begin : g_sext
      assign rawDisp = {{(DISP_W-DISP_SRC_W){fieldBits[DISP_SRC_W-1]}}, fieldBits[DISP_SRC_W-1:0]};
    end else begin : g_trunc
      assign rawDisp = fieldBits[DISP_W-1:0];
    end
  endgenerate

  always_comb begin
    nextT    = strobe.useT    ? fieldBits[T_LSB +: REG_W]     : '0;
    nextA    = strobe.useA    ? fieldBits[A_LSB +: REG_W]     : '0;
    nextB    = strobe.useB    ? fieldBits[B_LSB +: REG_W]     : '0;
    nextC    = strobe.useC    ? fieldBits[C_LSB +: REG_W]     : '0;
    nextCr   = strobe.useCr   ? fieldBits[CR_LSB +: CRF_W]    : '0;
    nextSrc  = strobe.useSrc  ? fieldBits[SRC_LSB +: CRF_W]   : '0;
    nextImm  = strobe.useImm  ? fieldBits[IMM_LSB +: IMM_W]   : '0;
    nextMask = strobe.useMask ? fieldBits[MASK_LSB +: MASK_W] : '0;
    nextDisp = strobe.useDisp ? rawDisp                       : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      opCode    <= '0;
      fmtClass  <= '0;
      addrMode  <= '0;
      isUpdate  <= 1'b0;
      recordBit <= 1'b0;
      isIllegal <= 1'b0;
      regT      <= '0;
      regA      <= '0;
      regB      <= '0;
      regC      <= '0;
      crField   <= '0;
      srcField  <= '0;
      immNib    <= '0;
      fieldMask <= '0;
      dispExt   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        opCode    <= info.opCode;
        fmtClass  <= info.fmt;
        addrMode  <= info.amode;
        isUpdate  <= info.update;
        recordBit <= info.record;
        isIllegal <= info.illegal;
        regT      <= nextT;
        regA      <= nextA;
        regB      <= nextB;
        regC      <= nextC;
        crField   <= nextCr;
        srcField  <= nextSrc;
        immNib    <= nextImm;
        fieldMask <= nextMask;
        dispExt   <= nextDisp;
      end
    end
  end

  // R1: strobe timing and hold
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(opCode) && $stable(regT) && $stable(dispExt)));

  // R3: a displacement update never leaves with a zero base
  p_upd_base_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && fmtClass == FMT_DISPU) |-> (addrMode == AM_BASE_DISP && regA != '0));

  // R5 / R6: index-only addressing only for update forms or the integer-word store
  p_idx_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && addrMode == AM_IDX_ONLY) |-> (regA == '0 && (isUpdate || opCode == OP_W'(16))));

  // R12: an illegal record carries no fields
  p_illegal_clean_r12: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && isIllegal) |-> (opCode == OP_BAD && !isUpdate && !recordBit &&
                                 regT == '0 && regB == '0 && dispExt == '0));
endmodule

// File: rtl/fp_insn_decode.sv
module fp_insn_decode
  import fpdec_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [INSN_W-1:0]   insn,
  output logic                outValid,
  output logic [OP_W-1:0]     opCode,
  output logic [3:0]          fmtClass,
  output logic [2:0]          addrMode,
  output logic                isUpdate,
  output logic                recordBit,
  output logic                isIllegal,
  output logic [REG_W-1:0]    regT,
  output logic [REG_W-1:0]    regA,
  output logic [REG_W-1:0]    regB,
  output logic [REG_W-1:0]    regC,
  output logic [CRF_W-1:0]    crField,
  output logic [CRF_W-1:0]    srcField,
  output logic [IMM_W-1:0]    immNib,
  output logic [MASK_W-1:0]   fieldMask,
  output logic [DISP_W-1:0]   dispExt
);
  decodeInfo_t  info;
  fieldStrobe_t strobe;

  fpdec_ctrl u_ctrl (
    .primary (insn[INSN_W-1 -: PRI_W]),
    .baseIdx (insn[20:16]),
    .extOp   (insn[EXT_W:1]),
    .recIn   (insn[0]),
    .info    (info),
    .strobe  (strobe)
  );

  fpdec_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .fieldBits (insn[FIELD_W-1:0]),
    .info      (info),
    .strobe    (strobe),
    .outValid  (outValid),
    .opCode    (opCode),
    .fmtClass  (fmtClass),
    .addrMode  (addrMode),
    .isUpdate  (isUpdate),
    .recordBit (recordBit),
    .isIllegal (isIllegal),
    .regT      (regT),
    .regA      (regA),
    .regB      (regB),
    .regC      (regC),
    .crField   (crField),
    .srcField  (srcField),
    .immNib    (immNib),
    .fieldMask (fieldMask),
    .dispExt   (dispExt)
  );
endmodule

// File: tb/test_fp_insn_decode.sv
`timescale 1ns/1ps
module test_fp_insn_decode;
  localparam int ODW = 87;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] insn = '0;
  logic        outValid;
  logic [6:0]  opCode;
  logic [3:0]  fmtClass;
  logic [2:0]  addrMode;
  logic        isUpdate, recordBit, isIllegal;
  logic [4:0]  regT, regA, regB, regC;
  logic [2:0]  crField, srcField;
  logic [3:0]  immNib;
  logic [7:0]  fieldMask;
  logic [31:0] dispExt;

  int checks = 0;
  int errors = 0;

  int xCodes[15] = '{0, 12, 14, 15, 32, 38, 40, 64, 70, 72, 134, 136, 264, 583, 711};
  int xFmts[15]  = '{8, 7, 7, 7, 8, 10, 7, 9, 10, 7, 11, 7, 7, 13, 12};

  always #2 clk = ~clk;

  fp_insn_decode i_fp_insn_decode (
    .clk(clk), .rstN(rstN), .inValid(inValid), .insn(insn),
    .outValid(outValid), .opCode(opCode), .fmtClass(fmtClass), .addrMode(addrMode),
    .isUpdate(isUpdate), .recordBit(recordBit), .isIllegal(isIllegal),
    .regT(regT), .regA(regA), .regB(regB), .regC(regC),
    .crField(crField), .srcField(srcField), .immNib(immNib),
    .fieldMask(fieldMask), .dispExt(dispExt)
  );

  function automatic logic [ODW-1:0] sampleOut();
    return {opCode, fmtClass, addrMode, isUpdate, recordBit, isIllegal,
            regT, regA, regB, regC, crField, srcField, immNib, fieldMask, dispExt};
  endfunction

  // Expected record built from the requirement text
  function automatic logic [ODW-1:0] model(input logic [31:0] w, output string tag);
    int p = int'(w[31:26]);
    int x = int'(w[10:1]);
    int s = int'(w[5:1]);
    int a = int'(w[20:16]);
    int op = -1;
    int fmt = 15;
    int am = 0;
    bit up = 0;
    bit rec = 0;
    logic [4:0] t, ra, rb, rc;
    logic [2:0] cr, src;
    logic [3:0] imm;
    logic [7:0] msk;
    logic [31:0] dsp;
    tag = "R12";
    if (p >= 48 && p <= 55) begin
      tag = "R2";
      op = p - 48;
      up = (p % 2) == 1;
      fmt = up ? 1 : 0;
      if (a == 0) begin
        tag = "R3";
        if (up) op = -1; else am = 2;
      end else am = 1;
    end else if (p == 31) begin
      tag = "R4";
      for (int k = 0; k < 8; k++) if (x == 535 + 32 * k) begin op = 8 + k; up = (k % 2) == 1; end
      if (x == 983) op = 16;
      if (op >= 0) begin
        fmt = up ? 3 : 2;
        if (a == 0) begin
          tag = up ? "R6" : "R5";
          if (up || op == 16) am = 4; else op = -1;
        end else am = 3;
      end else tag = "R12";
    end else if (p == 59) begin
      tag = "R7";
      if (s inside {18, 20, 21, 22, 24}) fmt = 4;
      else if (s == 25) fmt = 5;
      else if (s >= 28) fmt = 6;
      if (fmt != 15) begin op = 32 + s; rec = w[0]; end
    end else if (p == 63 && w[5]) begin
      tag = "R8";
      if (s inside {18, 20, 21, 22, 26}) fmt = 4;
      else if (s == 25) fmt = 5;
      else if (s == 23 || s >= 28) fmt = 6;
      if (fmt != 15) begin op = 64 + s; rec = w[0]; end
    end else if (p == 63) begin
      tag = "R9";
      for (int k = 0; k < 15; k++) if (x == xCodes[k]) begin op = 96 + k; fmt = xFmts[k]; end
      if (op >= 0) rec = w[0];
    end
    if (op < 0) begin
      return {7'h7F, 4'hF, 3'd0, 1'b0, 1'b0, 1'b1, 20'd0, 3'd0, 3'd0, 4'd0, 8'd0, 32'd0};
    end
    t   = (fmt inside {0, 1, 2, 3, 4, 5, 6, 7, 10, 13}) ? w[25:21] : 5'd0;
    ra  = (fmt inside {0, 1, 2, 3, 4, 5, 6, 8}) ? w[20:16] : 5'd0;
    rb  = (fmt inside {2, 3, 4, 6, 7, 8, 12}) ? w[15:11] : 5'd0;
    rc  = (fmt inside {5, 6}) ? w[10:6] : 5'd0;
    cr  = (fmt inside {8, 9, 11}) ? w[25:23] : 3'd0;
    src = (fmt == 9) ? w[20:18] : 3'd0;
    imm = (fmt == 11) ? w[15:12] : 4'd0;
    msk = (fmt == 12) ? w[24:17] : 8'd0;
    dsp = (fmt inside {0, 1}) ? {{16{w[15]}}, w[15:0]} : 32'd0;
    return {7'(op), 4'(fmt), 3'(am), up, rec, 1'b0, t, ra, rb, rc, cr, src, imm, msk, dsp};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [ODW-1:0] act, input logic [ODW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOne(input logic [31:0] w);
    logic [ODW-1:0] exp;
    logic [ODW-1:0] got;
    string tag;
    exp = model(w, tag);
    @(negedge clk);
    inValid = 1'b1;
    insn = w;
    @(negedge clk);
    got = sampleOut();
    check(outValid === 1'b1 && got === exp, {tag, " R10 R11"}, got, exp);
    inValid = 1'b0;
    insn = ~w;
    @(negedge clk);
    check(outValid === 1'b0 && sampleOut() === got, "R1 hold", sampleOut(), got);
  endtask

  function automatic logic [31:0] mkA(int p, int t, int a, int b, int c, int s, int rc);
    return {6'(p), 5'(t), 5'(a), 5'(b), 5'(c), 5'(s), 1'(rc)};
  endfunction

  function automatic logic [31:0] mkX(int p, logic [14:0] f, int xo, int rc);
    return {6'(p), f, 10'(xo), 1'(rc)};
  endfunction

  function automatic logic [31:0] mkD(int p, int t, int a, logic [15:0] d);
    return {6'(p), 5'(t), 5'(a), d};
  endfunction

  function automatic logic [31:0] pickInsn();
    logic [31:0] w;
    int r;
    w = $urandom;
    r = $urandom_range(0, 5);
    case (r)
      0: w[31:26] = 6'(48 + $urandom_range(0, 7));
      1: begin
        w[31:26] = 6'd31;
        if ($urandom_range(0, 8) == 0) w[10:1] = 10'd983;
        else w[10:1] = 10'(535 + 32 * $urandom_range(0, 7));
        if ($urandom_range(0, 9) == 0) w[10:1] = 10'($urandom);
      end
      2: begin w[31:26] = 6'd59; w[5:1] = 5'($urandom_range(16, 31)); end
      3: begin w[31:26] = 6'd63; w[5:1] = 5'($urandom_range(16, 31)); end
      4: begin
        w[31:26] = 6'd63;
        w[10:1] = 10'(xCodes[$urandom_range(0, 14)]);
        if ($urandom_range(0, 7) == 0) w[10:1] = 10'($urandom);
      end
      default: ;
    endcase
    if ($urandom_range(0, 3) == 0) w[20:16] = 5'd0;
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(outValid === 1'b0 && sampleOut() === '0, "R1 reset", sampleOut(), '0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 / R3 displacement corners
    runOne(mkD(49, 4, 0, 16'h0010));      // R3 update with zero base: illegal
    runOne(mkD(50, 7, 0, 16'h8000));      // R3 zero base, negative displacement
    runOne(mkD(55, 31, 3, 16'hFFFC));     // R2 store-double update
    runOne(mkD(48, 1, 2, 16'h7FFF));      // R2 positive displacement
    // R4 / R5 / R6 indexed corners
    runOne(mkX(31, {5'd9, 5'd0, 5'd7}, 983, 0));  // R5 exception
    runOne(mkX(31, {5'd9, 5'd0, 5'd7}, 535, 0));  // R5 illegal
    runOne(mkX(31, {5'd9, 5'd0, 5'd7}, 631, 1));  // R6 update zero base
    runOne(mkX(31, {5'd9, 5'd4, 5'd7}, 759, 0));  // R4
    runOne(mkX(31, {5'd9, 5'd4, 5'd7}, 536, 0));  // R12 unlisted
    // R7 / R8 group differences
    runOne(mkA(59, 1, 2, 3, 4, 23, 1));   // R7 select absent
    runOne(mkA(59, 1, 2, 3, 4, 26, 0));   // R7 rsqrt absent
    runOne(mkA(59, 1, 2, 3, 4, 24, 1));   // R7 reciprocal
    runOne(mkA(59, 5, 6, 7, 8, 25, 1));   // R7 multiply reads C
    runOne(mkA(63, 1, 2, 3, 4, 24, 0));   // R8 no reciprocal
    runOne(mkA(63, 1, 2, 3, 4, 23, 1));   // R8 select
    runOne(mkA(63, 1, 2, 3, 4, 26, 0));   // R8 rsqrt
    runOne(mkA(63, 1, 2, 3, 4, 17, 0));   // R8 unlisted
    // R9 / R10 X-form fields
    runOne(mkX(63, 15'h7FFF, 711, 1));    // R10 mask
    runOne(mkX(63, 15'h5A5A, 134, 0));    // R10 immediate
    runOne(mkX(63, 15'h6B3C, 64, 0));     // R10 field to condition
    runOne(mkX(63, 15'h3E1F, 38, 1));     // R10 bit number
    runOne(mkX(63, 15'h4321, 0, 0));      // R10 compare
    runOne(mkX(63, 15'h1234, 583, 1));    // R9 target only
    runOne(mkX(63, 15'h1234, 1, 0));      // R12 unlisted
    runOne(mkD(0, 1, 1, 16'h0001));       // R12 unknown primary

    for (int i = 0; i < 3000; i++) runOne(pickInsn());

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule